// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of a 16-pin general-purpose I/O port. A processor reaches it over a plain 32-bit register bus with address, write data, write and read strobes, read data and a ready flag. Through that bus software programs a two-bit mode for every pin, writes and reads the output data, reads the synchronised pin levels, and sets or clears single pins with one write, so it never needs a read-modify-write. The block drives the pad output values and output enables.

A port clock-enable input gates the whole register bus. While it is low, writes are dropped, reads return zero and ready stays low. After reset every pin is an input, the output data is zero and no pin is driven. Software first raises the enable, then programs the modes. After that it changes pins through the set/clear register or the output data register.

Top module: `gpio_port_regs`

## Requirements
- R1: The mode register sits at byte offset 0x00 and is read and written as a whole word. Pin p's mode occupies bits [2p+1:2p], coded 00 input, 01 output, 10 alternate, 11 analog.
- R2: `pinOe[p]` is 1 exactly when pin p's mode is 01 or 10. In modes 00 and 11 it is 0.
- R3: `pinOut[p]` equals `altOut[p]` when pin p is in mode 10. Otherwise it equals output data bit p.
- R4: The output data register at offset 0x14 is read/write. A write replaces all 16 bits from write data [15:0], and a read returns them in [15:0] with [31:16] zero.
- R5: A write at offset 0x18 sets output bit n when data bit n is 1 and clears it when data bit n+16 is 1. Bits whose set and clear bits are both 0 keep their value. The new value is readable from the output data register from the next cycle on.
- R6: When the set bit and the clear bit of one pin are both 1 in the same 0x18 write, the pin ends up set.
- R7: A read at offset 0x18 returns zero.
- R8: A read at offset 0x10 returns in [15:0] the value `pinIn` had two rising clock edges earlier, through a two-stage synchroniser, with [31:16] zero.
- R9: While `portClkEn` is 0, `busReady` is 0, `busRdata` is 0 and writes change no register. While it is 1, `busReady` equals `busWe | busRe`.
- R10: Reset clears the mode register and the output data register, so every `pinOe` bit is 0 and every `pinOut` bit is 0.
- R11: Reads at any offset other than 0x00, 0x10, 0x14 and 0x18 return zero, and writes there change no register. `busRdata` is zero whenever `busRe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| portClkEn | input | 1 | Port enable; gates all register access |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, taken at the rising edge |
| busRe | input | 1 | Read strobe; read data is combinational |
| busRdata | output | 32 | Read data, zero when no read is accepted |
| busReady | output | 1 | Access accepted in this cycle |
| pinIn | input | 16 | Raw pad input levels |
| altOut | input | 16 | Alternate function output values |
| pinOut | output | 16 | Pad output values |
| pinOe | output | 16 | Pad output enables |

## Verification
The assertions assume that the bus presents at most one of the four register offsets per cycle. They also assume that the address and write data are stable around the rising edge that takes a write. The synchroniser check further takes for granted that `pinIn` is sampled on the same clock as the block, with no setup hazard of its own. The stimulus meets these conditions because it changes every input one nanosecond after a rising edge. It mixes directed sequences with random accesses, and the random addresses include unaligned and unmapped offsets as well as periods with the port disabled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_MODE = 'h00;
  localparam int unsigned OFS_IDR  = 'h10;
  localparam int unsigned OFS_ODR  = 'h14;
  localparam int unsigned OFS_BSR  = 'h18;

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_MODE,
    RD_IDR,
    RD_ODR
  } rdSel_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic   modeWr;
    logic   odrWr;
    logic   bsrWr;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              portClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobe_t        strobe,
  output logic              busReady
);

  logic hitMode, hitIdr, hitOdr, hitBsr;
  logic wrOk, rdOk;

  assign hitMode = (busAddr == ADDR_W'(OFS_MODE));
  assign hitIdr  = (busAddr == ADDR_W'(OFS_IDR));
  assign hitOdr  = (busAddr == ADDR_W'(OFS_ODR));
  assign hitBsr  = (busAddr == ADDR_W'(OFS_BSR));

  assign wrOk = portClkEn && busWe;
  assign rdOk = portClkEn && busRe;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.modeWr = wrOk && hitMode;
    strobe.odrWr  = wrOk && hitOdr;
    strobe.bsrWr  = wrOk && hitBsr;
    if (rdOk) begin
      if (hitMode)     strobe.rdSel = RD_MODE;
      else if (hitIdr) strobe.rdSel = RD_IDR;
      else if (hitOdr) strobe.rdSel = RD_ODR;
      // the set/clear offset and unmapped offsets read as zero
    end
  end

  assign busReady = portClkEn && (busWe || busRe);

endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  regStrobe_t           strobe,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altOut,
  output logic [DATA_W-1:0]    busRdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] odrQ
);

  localparam int MODE_W = 2 * PIN_COUNT;  // must not exceed DATA_W

  logic [MODE_W-1:0]    modeQ;
  logic [PIN_COUNT-1:0] syncA, syncB;
  logic [PIN_COUNT-1:0] setBits, clrBits;

  assign setBits = busWdata[PIN_COUNT-1:0];
  assign clrBits = busWdata[MODE_W-1:PIN_COUNT];

  // Two-stage input synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeQ <= '0;
    else if (strobe.modeWr) modeQ <= busWdata[MODE_W-1:0];
  end

  // Set is applied after clear, so set wins on a conflict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odrQ <= '0;
    else if (strobe.odrWr) odrQ <= busWdata[PIN_COUNT-1:0];
    else if (strobe.bsrWr) odrQ <= (odrQ & ~clrBits) | setBits;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_MODE: busRdata = DATA_W'(modeQ);
      RD_IDR:  busRdata = DATA_W'(syncB);
      RD_ODR:  busRdata = DATA_W'(odrQ);
      default: busRdata = '0;
    endcase
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [1:0] pinMode;
    assign pinMode   = modeQ[2*p +: 2];
    assign pinOe[p]  = (pinMode == MODE_OUT) || (pinMode == MODE_ALT);
    assign pinOut[p] = (pinMode == MODE_ALT) ? altOut[p] : odrQ[p];
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 portClkEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 busWe,
  input  logic                 busRe,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busReady,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altOut,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);

  regStrobe_t           strobe;
  logic [PIN_COUNT-1:0] odrQ;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .portClkEn (portClkEn),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .strobe    (strobe),
    .busReady  (busReady)
  );

  gpio_port_dpath #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .altOut   (altOut),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .odrQ     (odrQ)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 portClkEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic                 busWe,
  input logic                 busRe,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 busReady,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] odrQ
);

  logic                 bsrHit, rdEn, mapped;
  logic [PIN_COUNT-1:0] setW, clrW;
  logic [1:0]           sinceRst;

  assign setW   = busWdata[PIN_COUNT-1:0];
  assign clrW   = busWdata[2*PIN_COUNT-1:PIN_COUNT];
  assign bsrHit = portClkEn && busWe && (busAddr == ADDR_W'(OFS_BSR));
  assign rdEn   = portClkEn && busRe;
  assign mapped = (busAddr == ADDR_W'(OFS_MODE)) || (busAddr == ADDR_W'(OFS_IDR)) ||
                  (busAddr == ADDR_W'(OFS_ODR))  || (busAddr == ADDR_W'(OFS_BSR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_blocked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !portClkEn |-> (!busReady && busRdata == '0));

  assert_blocked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !portClkEn |=> $stable(odrQ));

  // set bits land, including those whose clear bit is also 1 (R6)
  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsrHit |=> ((odrQ & $past(setW)) == $past(setW)));

  assert_clear_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsrHit |=> ((odrQ & $past(clrW) & ~$past(setW)) == '0));

  assert_untouched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsrHit |=> (((odrQ ^ $past(odrQ)) & ~($past(setW) | $past(clrW))) == '0));

  assert_bsr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && busAddr == ADDR_W'(OFS_BSR)) |-> busRdata == '0);

  assert_idr_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && busAddr == ADDR_W'(OFS_IDR) && sinceRst >= 2'd2) |->
      busRdata == DATA_W'($past(pinIn, 2)));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdEn && !mapped) || !busRe) |-> busRdata == '0);

endmodule

bind gpio_port_regs gpio_port_chk #(
  .PIN_COUNT (PIN_COUNT),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .portClkEn (portClkEn),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busWe     (busWe),
  .busRe     (busRe),
  .busRdata  (busRdata),
  .busReady  (busReady),
  .pinIn     (pinIn),
  .odrQ      (odrQ)
);

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

  localparam int PINS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        portClkEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [15:0] pinIn = '0;
  logic [15:0] altOut = '0;
  logic [15:0] pinOut;
  logic [15:0] pinOe;

  int compared = 0;
  int mismatched = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  gpio_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .portClkEn(portClkEn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .busReady(busReady), .pinIn(pinIn), .altOut(altOut), .pinOut(pinOut), .pinOe(pinOe)
  );

  // Behavioural reference model
  logic [31:0] refMode;
  logic [15:0] refOdr;
  logic [15:0] syncQ[$];  // pinIn history, oldest first, two deep

  always @(posedge clk) begin
    if (!rst_n) begin
      refMode <= '0;
      refOdr  <= '0;
      syncQ = '{16'h0, 16'h0};
    end else begin
      syncQ.push_back(pinIn);
      void'(syncQ.pop_front());
      if (portClkEn && busWe) begin
        if (busAddr == 8'h00) refMode <= busWdata;
        else if (busAddr == 8'h14) refOdr <= busWdata[15:0];
        else if (busAddr == 8'h18) begin
          for (int n = 0; n < PINS; n++) begin
            if (busWdata[n])         refOdr[n] <= 1'b1;
            else if (busWdata[n+16]) refOdr[n] <= 1'b0;
          end
        end
      end
    end
  end

  function automatic void check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endfunction

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !doneFlag) begin
      logic [15:0] expOe, expOut;
      logic [31:0] expRd;
      string rdTag;
      for (int p = 0; p < PINS; p++) begin
        logic [1:0] m;
        m = refMode[2*p +: 2];
        expOe[p]  = (m == 2'b01) || (m == 2'b10);
        expOut[p] = (m == 2'b10) ? altOut[p] : refOdr[p];
      end
      expRd = '0;
      rdTag = "R11";
      if (!portClkEn) rdTag = "R9";
      else if (busRe) begin
        case (busAddr)
          8'h00: begin expRd = refMode; rdTag = "R1"; end
          8'h10: begin expRd = {16'h0, syncQ[0]}; rdTag = "R8"; end
          8'h14: begin expRd = {16'h0, refOdr}; rdTag = "R4"; end
          8'h18: rdTag = "R7";
          default: rdTag = "R11";
        endcase
      end
      check("R2", "pinOe", {16'h0, pinOe}, {16'h0, expOe});
      check("R3", "pinOut", {16'h0, pinOut}, {16'h0, expOut});
      check("R9", "busReady", {31'h0, busReady}, {31'h0, portClkEn & (busWe | busRe)});
      check(rdTag, "busRdata", busRdata, expRd);
    end
  end

  task automatic busOp(input logic we, input logic re, input logic [7:0] a, input logic [31:0] d);
    busWe = we; busRe = re; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0; busRe = 1'b0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    busRe = 1'b1; busAddr = a; busWe = 1'b0;
    @(negedge clk);
    check(req, "directed read", busRdata, exp);
    @(posedge clk); #1;
    busRe = 1'b0;
  endtask

  task automatic expectPins(input logic [15:0] oe, input logic [15:0] out, input string req);
    @(negedge clk);
    check(req, "directed pinOe", {16'h0, pinOe}, {16'h0, oe});
    check(req, "directed pinOut", {16'h0, pinOut}, {16'h0, out});
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] addrPool [8];
    addrPool = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h04, 8'h1C, 8'h12, 8'h20};
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset pinOe", {16'h0, pinOe}, 32'h0);
    check("R10", "reset pinOut", {16'h0, pinOut}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R9: port disabled, writes are dropped
    busOp(1, 0, 8'h00, 32'h5555_5555);
    busOp(1, 0, 8'h14, 32'h0000_FFFF);
    busRe = 1'b1; busAddr = 8'h00;
    @(negedge clk);
    check("R9", "disabled ready", {31'h0, busReady}, 32'h0);
    check("R9", "disabled rdata", busRdata, 32'h0);
    @(posedge clk); #1; busRe = 1'b0;
    portClkEn = 1'b1;
    expectRead(8'h00, 32'h0, "R9");
    expectRead(8'h14, 32'h0, "R10");

    // R1: pins 0-3 output, 4-7 alternate, 8-11 analog, 12-15 input
    busOp(1, 0, 8'h00, 32'h00FF_AA55);
    expectRead(8'h00, 32'h00FF_AA55, "R1");
    // R4: full replace, upper half reads zero
    busOp(1, 0, 8'h14, 32'h1234_A5A5);
    expectRead(8'h14, 32'h0000_A5A5, "R4");
    // R5: clear bit 0, set bit 1
    busOp(1, 0, 8'h18, 32'h0001_0002);
    expectRead(8'h14, 32'h0000_A5A6, "R5");
    // R6: bit 3 set and clear together -> set; bit 15 cleared
    busOp(1, 0, 8'h18, 32'h8008_0008);
    expectRead(8'h14, 32'h0000_25AE, "R6");
    expectRead(8'h18, 32'h0, "R7");
    // R2/R3: alternate pins follow altOut
    altOut = 16'h0050;
    expectPins(16'h00FF, 16'h255E, "R3");
    expectPins(16'h00FF, 16'h255E, "R2");

    // R8: two-edge synchroniser latency
    pinIn = 16'hBEEF;
    expectRead(8'h10, 32'h0, "R8");
    expectRead(8'h10, 32'h0, "R8");
    expectRead(8'h10, 32'h0000_BEEF, "R8");

    // R11: unmapped offsets
    busOp(1, 0, 8'h04, 32'hFFFF_FFFF);
    busOp(1, 0, 8'h16, 32'hFFFF_FFFF);
    expectRead(8'h04, 32'h0, "R11");
    expectRead(8'h1C, 32'h0, "R11");
    expectRead(8'h14, 32'h0000_25AE, "R11");
    expectRead(8'h00, 32'h00FF_AA55, "R11");

    // R9: set/clear while disabled has no effect
    portClkEn = 1'b0;
    busOp(1, 0, 8'h18, 32'hFFFF_0000);
    portClkEn = 1'b1;
    expectRead(8'h14, 32'h0000_25AE, "R9");

    // Random traffic checked cycle by cycle against the model
    for (int i = 0; i < 3000; i++) begin
      portClkEn = ($urandom_range(0, 9) != 0);
      pinIn     = 16'($urandom);
      altOut    = 16'($urandom);
      busWe     = ($urandom_range(0, 2) == 0);
      busRe     = ($urandom_range(0, 1) == 0);
      busAddr   = addrPool[$urandom_range(0, 7)];
      busWdata  = $urandom;
      @(posedge clk); #1;
    end
    busWe = 1'b0; busRe = 1'b0;
    @(posedge clk); #1;
    finishRun();
  end

endmodule